// File: doc/BRIEF.md
# System Control Register Block

This block is the host-facing control register file of a multi-function I/O companion device. A host reaches it through an 8-bit, byte-addressed read/write port. Behind that port the block does three jobs. First, it gathers eight sub-function interrupt lines into a status byte and combines that byte with a host-written mask to drive one host interrupt line. Second, it drives a general-purpose output port of 16 lines, each with its own output enable. Third, it holds a set of configuration bytes for clock, PLL, mode and function-enable settings that other logic reads.

The general-purpose output port reports its own activity. After each write to its data or enable bytes, it pulses a one-cycle change strobe on every line whose driven level moved. Downstream logic only needs to react to those strobes; it never has to poll the level.

Wide configuration registers take up consecutive byte addresses, with the least significant byte at the lowest address. Each byte is written on its own. The block does not answer addresses outside its map. Such an access reads as zero and sets a sticky error flag.

Top module: `sysctl_regs`

## Requirements
- R1: Bit n of the status byte (read at offset 0x50) equals sub-interrupt line n as sampled at the previous clock edge. Lines are numbered 0 NAND, 1 MMC, 2 USB host, 3 serial, 4 framebuffer, and 5 to 7 are spare.
- R2: `host_irq` is high exactly when the status byte ANDed with the mask byte (read/write at offset 0x52) is non-zero. It follows a line change one cycle later.
- R3: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset change nothing and do not set the error flag.
- R4: The output data register (offsets 0x78, 0x79, 0x7A) and the output-enable register (offsets 0x7C, 0x7D, 0x7E) are 24 bits each. Byte k maps to bits 8k+7..8k, and a read of byte k returns that same slice.
- R5: `gpo_level` equals bits 15..0 of (data AND enable). It changes only in the cycle after a write to one of the six output offsets.
- R6: After each output write, `gpo_chg` is high for exactly one cycle, on each line whose driven level differs from the level before that write. In every other cycle it is zero.
- R7: The configuration bytes are read/write at offsets 0x54, 0x60 to 0x61, 0x98 to 0x9F, 0xE0, 0xE4 to 0xE5, 0xFC and 0xFF. A byte write changes only the byte it addresses.
- R8: An access to any other offset reads 0x00 and writes nothing. A read or write there sets `err`, which stays high until reset.
- R9: Synchronous active-high reset clears every stored byte, the status byte, `err`, the driven level and the strobes.
- R10: The status byte is read-only. A write to 0x50 leaves it tracking the lines and does not set `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe (used for error tracking) |
| addr | input | 8 | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| sub_irq | input | 8 | Sub-function interrupt lines |
| host_irq | output | 1 | Masked combined interrupt |
| gpo_level | output | 16 | Driven output levels |
| gpo_chg | output | 16 | One-cycle per-line change strobes |
| err | output | 1 | Sticky unmapped-access flag |

## Verification
The bench writes output data and enable bytes so that some lines toggle and others only see their enable move while the data stays low. A design that strobed on raw data changes, or that did not mask with the enable, would pulse lines whose driven level stayed the same. It writes single bytes of multi-byte configuration registers and reads the other lanes back, which exposes a design that clears or shifts neighbouring lanes. It also aims writes at the revision and status offsets and reaches for unmapped holes next to mapped ones (0x0A, 0x7B, 0x7F, 0xFE). Off-by-one decoding there would either corrupt storage or miss the sticky error. Finally, it drops a line while its mask bit is set, to catch an interrupt output that latches rather than tracks.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int IRQ_LINES = 8;
    localparam int GPO_LINES = 16;
    localparam int GPO_LANES = 3;
    localparam int CFG_BYTES = 16;
    localparam int CFG_IDX_W = $clog2(CFG_BYTES);

    localparam logic [ADDR_W-1:0] OFS_REV_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_REV_HI  = 8'h09;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h52;
    localparam logic [ADDR_W-1:0] OFS_GPO_DAT = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_GPO_ENA = 8'h7C;
    localparam logic [DATA_W-1:0] REV_CODE    = 8'h03;

    typedef struct packed {
        logic                 hit;
        logic [CFG_IDX_W-1:0] idx;
    } cfg_sel_t;

    // Map a byte offset onto a configuration storage slot.
    function automatic cfg_sel_t cfg_lookup(input logic [ADDR_W-1:0] a);
        cfg_sel_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (a)
            8'h54: s.idx = CFG_IDX_W'(0);
            8'h60: s.idx = CFG_IDX_W'(1);
            8'h61: s.idx = CFG_IDX_W'(2);
            8'h98, 8'h99, 8'h9A, 8'h9B,
            8'h9C, 8'h9D, 8'h9E, 8'h9F:
                   s.idx = CFG_IDX_W'(a - 8'h98 + 8'd3);
            8'hE0: s.idx = CFG_IDX_W'(11);
            8'hE4: s.idx = CFG_IDX_W'(12);
            8'hE5: s.idx = CFG_IDX_W'(13);
            8'hFC: s.idx = CFG_IDX_W'(14);
            8'hFF: s.idx = CFG_IDX_W'(15);
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sysctl_cfg_store.sv
module sysctl_cfg_store
    import sysctl_pkg::*;
#(
    parameter int NBYTES = CFG_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);

    cfg_sel_t sel;
    logic [NBYTES-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        sel   = cfg_lookup(addr);
        hit   = sel.hit;
        mem_d = mem_q;
        if (wr_en && sel.hit) begin
            mem_d[sel.idx] = wdata;
        end
        rdata = sel.hit ? mem_q[sel.idx] : '0;
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

endmodule

// File: rtl/sysctl_irq_agg.sv
module sysctl_irq_agg
    import sysctl_pkg::*;
#(
    parameter int LINES = IRQ_LINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINES-1:0]  sub_irq,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic              host_irq
);

    typedef struct packed {
        logic [LINES-1:0] status;
        logic [LINES-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = sub_irq;
        if (wr_en && addr == OFS_MASK) begin
            st_d.mask = wdata[LINES-1:0];
        end
        hit   = (addr == OFS_STATUS) || (addr == OFS_MASK);
        rdata = '0;
        if (addr == OFS_STATUS) begin
            rdata[LINES-1:0] = st_q.status;
        end else if (addr == OFS_MASK) begin
            rdata[LINES-1:0] = st_q.mask;
        end
        host_irq = |(st_q.status & st_q.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sysctl_gpo.sv
module sysctl_gpo
    import sysctl_pkg::*;
#(
    parameter int LINES = GPO_LINES,
    parameter int LANES = GPO_LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    output logic [LINES-1:0]  level,
    output logic [LINES-1:0]  chg
);

    localparam int REG_W = LANES * DATA_W;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] oe;
        logic [LINES-1:0] level;
        logic [LINES-1:0] chg;
    } gpo_state_t;

    gpo_state_t       st_d, st_q;
    logic [LANES-1:0] dat_sel, ena_sel;
    logic [REG_W-1:0] drive_full;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign dat_sel[k] = (addr == OFS_GPO_DAT + ADDR_W'(k));
        assign ena_sel[k] = (addr == OFS_GPO_ENA + ADDR_W'(k));
    end

    always_comb begin
        st_d     = st_q;
        st_d.chg = '0;
        rdata    = '0;
        hit      = |{dat_sel, ena_sel};
        for (int k = 0; k < LANES; k++) begin
            if (wr_en && dat_sel[k]) st_d.data[k*DATA_W +: DATA_W] = wdata;
            if (wr_en && ena_sel[k]) st_d.oe[k*DATA_W +: DATA_W]   = wdata;
            if (dat_sel[k]) rdata = st_q.data[k*DATA_W +: DATA_W];
            if (ena_sel[k]) rdata = st_q.oe[k*DATA_W +: DATA_W];
        end
        drive_full = st_d.data & st_d.oe;
        if (wr_en && hit) begin
            st_d.level = drive_full[LINES-1:0];
            st_d.chg   = drive_full[LINES-1:0] ^ st_q.level;
        end
        level = st_q.level;
        chg   = st_q.chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [IRQ_LINES-1:0] sub_irq,
    output logic                 host_irq,
    output logic [GPO_LINES-1:0] gpo_level,
    output logic [GPO_LINES-1:0] gpo_chg,
    output logic                 err
);

    typedef struct packed {
        logic err;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              irq_hit, gpo_hit, cfg_hit, rev_hit;
    logic [DATA_W-1:0] irq_rd, gpo_rd, cfg_rd, rev_rd;

    sysctl_irq_agg #(.LINES(IRQ_LINES)) u_irq (
        .clk, .rst, .wr_en, .addr, .wdata, .sub_irq,
        .hit(irq_hit), .rdata(irq_rd), .host_irq
    );

    sysctl_gpo #(.LINES(GPO_LINES), .LANES(GPO_LANES)) u_gpo (
        .clk, .rst, .wr_en, .addr, .wdata,
        .hit(gpo_hit), .rdata(gpo_rd), .level(gpo_level), .chg(gpo_chg)
    );

    sysctl_cfg_store #(.NBYTES(CFG_BYTES)) u_cfg (
        .clk, .rst, .wr_en, .addr, .wdata,
        .hit(cfg_hit), .rdata(cfg_rd)
    );

    always_comb begin
        rev_hit = (addr == OFS_REV_LO) || (addr == OFS_REV_HI);
        rev_rd  = (addr == OFS_REV_LO) ? REV_CODE : '0;
        rdata   = irq_rd | gpo_rd | cfg_rd | rev_rd;
        st_d    = st_q;
        if ((wr_en || rd_en) && !(rev_hit || irq_hit || gpo_hit || cfg_hit)) begin
            st_d.err = 1'b1;
        end
        err = st_q.err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sysctl_regs_sva.sv
module sysctl_regs_sva
    import sysctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    rdata,
    input logic [IRQ_LINES-1:0] sub_irq,
    input logic                 host_irq,
    input logic [GPO_LINES-1:0] gpo_level,
    input logic [GPO_LINES-1:0] gpo_chg,
    input logic                 err
);

    logic gpo_wr;
    assign gpo_wr = wr_en &&
        ((addr >= OFS_GPO_DAT && addr < OFS_GPO_DAT + ADDR_W'(GPO_LANES)) ||
         (addr >= OFS_GPO_ENA && addr < OFS_GPO_ENA + ADDR_W'(GPO_LANES)));

    p_irq_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (sub_irq == '0) |=> !host_irq);

    p_rev_code_r3: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_REV_LO) |-> (rdata == REV_CODE));

    p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !gpo_wr |=> $stable(gpo_level));

    p_chg_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !gpo_wr |=> (gpo_chg == '0));

    p_chg_match_r6: assert property (@(posedge clk) disable iff (rst)
        gpo_wr |=> (gpo_chg == (gpo_level ^ $past(gpo_level))));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

bind sysctl_regs sysctl_regs_sva u_sva (
    .clk, .rst, .wr_en, .addr, .rdata, .sub_irq, .host_irq,
    .gpo_level, .gpo_chg, .err
);

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0, wdata = '0, rdata;
    logic [7:0]  sub_irq = '0;
    logic        host_irq, err;
    logic [15:0] gpo_level, gpo_chg;

    int checks = 0, failures = 0;
    logic [7:0]  mem_m [256];
    logic [15:0] lvl_m = '0;
    logic        err_m = 1'b0;
    logic [7:0]  sub_m = '0;

    always #4 clk = ~clk;

    sysctl_regs uut (.*);

    initial begin
        #1_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic bit is_store(input logic [7:0] a);
        return a == 8'h52 || a == 8'h54 || a == 8'h60 || a == 8'h61 ||
               (a >= 8'h78 && a <= 8'h7A) || (a >= 8'h7C && a <= 8'h7E) ||
               (a >= 8'h98 && a <= 8'h9F) || a == 8'hE0 || a == 8'hE4 ||
               a == 8'hE5 || a == 8'hFC || a == 8'hFF;
    endfunction

    function automatic bit is_mapped(input logic [7:0] a);
        return is_store(a) || a == 8'h08 || a == 8'h09 || a == 8'h50;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h08) return 8'h03;
        if (a == 8'h50) return sub_m;
        if (is_store(a)) return mem_m[a];
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_level();
        return {mem_m[8'h79] & mem_m[8'h7D], mem_m[8'h78] & mem_m[8'h7C]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        logic [15:0] old;
        bit g;
        old = lvl_m;
        g = (a >= 8'h78 && a <= 8'h7A) || (a >= 8'h7C && a <= 8'h7E);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (is_store(a)) mem_m[a] = d;
        if (!is_mapped(a)) err_m = 1'b1;
        if (g) begin
            lvl_m = exp_level();
            check("R5 level", gpo_level, lvl_m);
            check("R6 strobe", gpo_chg, lvl_m ^ old);
            @(negedge clk);
            check("R6 strobe clears", gpo_chg, 16'h0);
        end else begin
            check("R5 level held", gpo_level, lvl_m);
        end
        check("R8 err", err, err_m);
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, rdata, exp_read(a));
        @(negedge clk);
        rd_en = 1'b0;
        if (!is_mapped(a)) err_m = 1'b1;
        check("R8 err after read", err, err_m);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        sub_irq = v;
        @(negedge clk);
        sub_m = v;
        check("R2 host_irq", host_irq, |(sub_m & mem_m[8'h52]));
        do_read(8'h50, "R1 status");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 gpo_level", gpo_level, 16'h0);
        check("R9 gpo_chg", gpo_chg, 16'h0);
        check("R9 err", err, 1'b0);
        check("R9 host_irq", host_irq, 1'b0);
        do_read(8'h9C, "R9 cfg cleared");
        // R3
        do_read(8'h08, "R3 rev lo");
        do_read(8'h09, "R3 rev hi");
        do_write(8'h08, 8'h55);
        do_read(8'h08, "R3 rev after write");
        // R1 / R2 / R10
        do_write(8'h52, 8'h12);
        set_irq(8'h01);
        set_irq(8'h10);
        set_irq(8'h02);
        do_write(8'h50, 8'hFF);
        do_read(8'h50, "R10 status read-only");
        set_irq(8'h00);
        // R4 / R5 / R6 directed
        do_write(8'h78, 8'hF0);
        do_write(8'h7C, 8'h3C);
        do_write(8'h79, 8'hA5);
        do_write(8'h7D, 8'hFF);
        do_write(8'h7C, 8'hFF);
        do_write(8'h7A, 8'h77);
        do_write(8'h7E, 8'h99);
        do_read(8'h7A, "R4 lane2 data");
        do_read(8'h7E, "R4 lane2 oe");
        do_write(8'h78, 8'h00);
        do_write(8'h7C, 8'h00);
        do_write(8'h7C, 8'h0F);
        // R7 lanes
        do_write(8'h9C, 8'h11); do_write(8'h9D, 8'h22);
        do_write(8'h9E, 8'h33); do_write(8'h9F, 8'h44);
        do_write(8'h9D, 8'hEE);
        do_read(8'h9C, "R7 pll b0"); do_read(8'h9D, "R7 pll b1");
        do_read(8'h9E, "R7 pll b2"); do_read(8'h9F, "R7 pll b3");
        do_write(8'h61, 8'hAB);
        do_read(8'h60, "R7 gp-enable lo"); do_read(8'h61, "R7 gp-enable hi");
        // R8 holes
        do_read(8'h0A, "R8 unmapped read");
        do_write(8'h7B, 8'h5A);
        do_read(8'h7B, "R8 unmapped 7B");
        do_write(8'hFE, 8'h11);
        do_read(8'h7F, "R8 unmapped 7F");
        do_read(8'hFF, "R7 neighbour of hole");
        // random mix
        for (int n = 0; n < 500; n++) begin
            int op;
            logic [7:0] a;
            op = $urandom_range(0, 3);
            a  = 8'($urandom);
            case (op)
                0: do_write(8'h78 + 8'($urandom_range(0, 6)), 8'($urandom));
                1: do_write(a, 8'($urandom));
                2: do_read(a, "R7 random read");
                default: set_irq(8'($urandom));
            endcase
        end
        // R9 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        lvl_m = '0; err_m = 1'b0; sub_m = sub_irq;
        @(negedge clk);
        check("R9 level after reset", gpo_level, 16'h0);
        check("R9 err after reset", err, 1'b0);
        do_read(8'hE4, "R9 cfg after reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule